// File: doc/BRIEF.md
# DMA Address Translation Page Walker

This block turns a 32-bit address issued by a DMA device into a 36-bit physical address. It does this by fetching one 32-bit entry from a single-level translation table in memory. Requests arrive one at a time over a valid/ready handshake. The walker derives the table entry address from a configured table base and a configured window size. It issues a single read on its memory port and rebuilds the entry from big-endian byte lanes. It then checks the entry's permission bits and returns either a translation or a fault.

A translation carries the physical address, the page base, a 4 KB offset mask and a read-only or read-write permission. A fault carries no translation. A fault also loads a status word and the faulting page address into registers and raises an interrupt line. The interrupt stays high until the owner acknowledges it. There is no entry cache: every request costs one memory read.

Top module: `dma_xlate_walker`

## Requirements
- R1: `req_ready_o` is high only while the walker is idle. After a request is accepted, no further request is accepted until the response to it has been taken.
- R2: For each request the walker reads exactly one entry, at address `{cfg_base_i, 4'b0} + ((((addr & ~0xFFF) & M) >> 10) & ~3)`. Here `M = 2^(24+cfg_range_i) - 1`, so range code 0 covers a 16 MB window and code 7 covers a 2 GB window. Address bits above the window are ignored.
- R3: The entry is big-endian across the byte lanes of `mem_rdata_i`. Lane `[7:0]` holds entry bits 31:24, lane `[15:8]` holds bits 23:16, lane `[23:16]` holds bits 15:8 and lane `[31:24]` holds bits 7:0.
- R4: On success, `rsp_pa_o = {entry[31:8], addr[11:0]}`.
- R5: On success, `rsp_perm_o` is 2'b11 (read-write) when entry bit 2 is set and 2'b01 (read-only) otherwise. `rsp_iova_o` is the request address with bits 11:0 cleared, and `rsp_mask_o` is 0x00000FFF.
- R6: An entry whose bit 1 (valid) is clear produces a fault, whatever its other bits and whatever the direction of the request.
- R7: A write request (`req_write_i`=1) to a valid entry whose bit 2 is clear produces a fault. A read request to the same entry succeeds.
- R8: A fault loads `fault_status_o` with 0xC0820000 for a write or 0xC0860000 for a read (bit 18 marks a read). It loads `fault_addr_o` with the page address and sets `irq_o`. All of this is visible by the time the response is valid.
- R9: A fault response has `rsp_fault_o`=1, `rsp_perm_o`=2'b00, `rsp_pa_o`=0, `rsp_iova_o`=0 and `rsp_mask_o`=0xFFFFFFFF.
- R10: Once raised, `rsp_valid_o` and all response fields hold steady until `rsp_ready_i` is high at a clock edge.
- R11: A pulse on `fault_ack_i` clears `irq_o` and leaves `fault_status_o` and `fault_addr_o` unchanged.
- R12: After reset, `fault_status_o` is 0x00800000, `fault_addr_o` is 0, `irq_o` is 0, `req_ready_o` is 1, and `rsp_valid_o` and `mem_req_o` are 0.
- R13: `mem_req_o` and `mem_addr_o` hold steady until `mem_gnt_i` is seen. The entry is taken on the cycle `mem_rvalid_i` is high, which may come any number of cycles after the grant.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_base_i | input | 32 | Table base; shifted left by 4 to form a byte address |
| cfg_range_i | input | 3 | Window size code, 16 MB << code |
| req_valid_i | input | 1 | Translation request valid |
| req_ready_o | output | 1 | Walker can accept a request |
| req_addr_i | input | 32 | Device address to translate |
| req_write_i | input | 1 | 1 = write access, 0 = read access |
| mem_req_o | output | 1 | Entry read request |
| mem_gnt_i | input | 1 | Memory accepted the read |
| mem_addr_o | output | 36 | Byte address of the entry |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 32 | Read data, byte lanes in address order |
| rsp_valid_o | output | 1 | Response valid |
| rsp_ready_i | input | 1 | Requester takes the response |
| rsp_fault_o | output | 1 | Translation failed |
| rsp_perm_o | output | 2 | 00 none, 01 read-only, 11 read-write |
| rsp_pa_o | output | 36 | Physical address |
| rsp_iova_o | output | 32 | Page base of the request |
| rsp_mask_o | output | 32 | Offset mask of the translation |
| fault_ack_i | input | 1 | Clears the interrupt |
| fault_status_o | output | 32 | Fault status word |
| fault_addr_o | output | 32 | Page address of the last fault |
| irq_o | output | 1 | Fault interrupt |

## Verification
The embedded properties assume the memory side behaves well. It grants only while a request is up, and it returns exactly one `mem_rvalid_i` strobe per grant, never before that grant. The properties also assume `fault_ack_i` is not pulsed in the cycle a fault is being recorded. The bench memory model waits for `mem_req_o` before granting and sends one data strobe after a varying delay. It pulses the acknowledge only after the queue of outstanding responses has drained. Response back-pressure comes from a repeating stall pattern, so the hold property is exercised without creating conditions the block does not allow.

// File: rtl/dxw_pkg.sv
package dxw_pkg;
    localparam int VA_W         = 32;
    localparam int PA_W         = 36;
    localparam int PTE_W        = 32;
    localparam int PAGE_SHIFT   = 12;
    localparam int RANGE_W      = 3;
    localparam int MIN_WIN_LOG2 = 24;
    localparam int BASE_SHIFT   = 4;
    localparam int BYTE_W       = 8;
    localparam int LANES        = PTE_W / BYTE_W;
    localparam int PPN_W        = PA_W - PAGE_SHIFT;
    localparam int PPN_LSB      = PTE_W - PPN_W;
    localparam int IDX_SHIFT    = PAGE_SHIFT - 2;

    localparam int PTE_VALID_BIT = 1;
    localparam int PTE_WRITE_BIT = 2;

    localparam logic [31:0] FST_ERR   = 32'h8000_0000;
    localparam logic [31:0] FST_LATE  = 32'h4000_0000;
    localparam logic [31:0] FST_RESV  = 32'h0080_0000;
    localparam logic [31:0] FST_READ  = 32'h0004_0000;
    localparam logic [31:0] FST_AVAL  = 32'h0002_0000;
    localparam logic [31:0] FST_FAULT = FST_ERR | FST_LATE | FST_RESV | FST_AVAL;

    typedef enum logic [2:0] {
        ST_IDLE, ST_ISSUE, ST_WAIT, ST_CHECK, ST_RESP
    } walk_st_e;

    typedef enum logic [1:0] {
        PERM_NONE = 2'b00,
        PERM_RO   = 2'b01,
        PERM_RW   = 2'b11
    } perm_e;

    typedef struct packed {
        logic              fault;
        perm_e             perm;
        logic [PA_W-1:0]   pa;
        logic [VA_W-1:0]   iova;
        logic [VA_W-1:0]   mask;
    } xlate_rsp_t;

    function automatic logic [VA_W-1:0] win_mask(input logic [RANGE_W-1:0] code);
        logic [VA_W-1:0] one;
        one = 1;
        return (one << (MIN_WIN_LOG2 + int'(code))) - one;
    endfunction

    function automatic logic [PTE_W-1:0] be_assemble(input logic [PTE_W-1:0] lanes);
        logic [PTE_W-1:0] w;
        for (int i = 0; i < LANES; i++) begin
            w[PTE_W-1-i*BYTE_W -: BYTE_W] = lanes[i*BYTE_W +: BYTE_W];
        end
        return w;
    endfunction
endpackage

// File: rtl/dxw_entry_addr.sv
module dxw_entry_addr
    import dxw_pkg::*;
(
    input  logic [VA_W-1:0]    base_i,
    input  logic [VA_W-1:0]    page_i,
    input  logic [RANGE_W-1:0] range_i,
    output logic [PA_W-1:0]    addr_o
);
    logic [VA_W-1:0] idx;

    always_comb begin
        idx      = (page_i & win_mask(range_i)) >> IDX_SHIFT;
        idx[1:0] = 2'b00;
        addr_o   = PA_W'({base_i, {BASE_SHIFT{1'b0}}}) + PA_W'(idx);
    end
endmodule

// File: rtl/dxw_pte_check.sv
module dxw_pte_check
    import dxw_pkg::*;
(
    input  logic [PTE_W-1:0]      pte_i,
    input  logic [VA_W-1:0]       page_i,
    input  logic [PAGE_SHIFT-1:0] off_i,
    input  logic                  write_i,
    output xlate_rsp_t            rsp_o
);
    logic valid, wr_ok, fault;
    logic unused_pte_bits;

    assign valid = pte_i[PTE_VALID_BIT];
    assign wr_ok = pte_i[PTE_WRITE_BIT];
    assign fault = !valid || (write_i && !wr_ok);
    assign unused_pte_bits = ^{pte_i[PPN_LSB-1:PTE_WRITE_BIT+1], pte_i[0]};

    always_comb begin
        rsp_o.fault = fault;
        if (fault) begin
            rsp_o.perm = PERM_NONE;
            rsp_o.pa   = '0;
            rsp_o.iova = '0;
            rsp_o.mask = '1;
        end else begin
            rsp_o.perm = wr_ok ? PERM_RW : PERM_RO;
            rsp_o.pa   = {pte_i[PTE_W-1:PPN_LSB], off_i};
            rsp_o.iova = page_i;
            rsp_o.mask = VA_W'((1 << PAGE_SHIFT) - 1);
        end
    end
endmodule

// File: rtl/dxw_fault_regs.sv
module dxw_fault_regs
    import dxw_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            set_i,
    input  logic            set_read_i,
    input  logic [VA_W-1:0] set_addr_i,
    input  logic            ack_i,
    output logic [31:0]     status_o,
    output logic [VA_W-1:0] addr_o,
    output logic            irq_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            status_o <= FST_RESV;
            addr_o   <= '0;
            irq_o    <= 1'b0;
        end else if (set_i) begin
            status_o <= FST_FAULT | (set_read_i ? FST_READ : 32'h0);
            addr_o   <= set_addr_i;
            irq_o    <= 1'b1;
        end else if (ack_i) begin
            irq_o    <= 1'b0;
        end
    end

    assert_irq_cause_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_o) |-> (status_o[31] && status_o[30] && status_o[17]));
    assert_ack_clears_R11: assert property (@(posedge clk) disable iff (rst)
        (ack_i && !set_i) |=> (!irq_o && $stable(status_o) && $stable(addr_o)));
    assert_resv_bit_R12: assert property (@(posedge clk) disable iff (rst)
        status_o[23]);
endmodule

// File: rtl/dma_xlate_walker.sv
module dma_xlate_walker
    import dxw_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [VA_W-1:0]      cfg_base_i,
    input  logic [RANGE_W-1:0]   cfg_range_i,
    input  logic                 req_valid_i,
    output logic                 req_ready_o,
    input  logic [VA_W-1:0]      req_addr_i,
    input  logic                 req_write_i,
    output logic                 mem_req_o,
    input  logic                 mem_gnt_i,
    output logic [PA_W-1:0]      mem_addr_o,
    input  logic                 mem_rvalid_i,
    input  logic [PTE_W-1:0]     mem_rdata_i,
    output logic                 rsp_valid_o,
    input  logic                 rsp_ready_i,
    output logic                 rsp_fault_o,
    output logic [1:0]           rsp_perm_o,
    output logic [PA_W-1:0]      rsp_pa_o,
    output logic [VA_W-1:0]      rsp_iova_o,
    output logic [VA_W-1:0]      rsp_mask_o,
    input  logic                 fault_ack_i,
    output logic [31:0]          fault_status_o,
    output logic [VA_W-1:0]      fault_addr_o,
    output logic                 irq_o
);
    walk_st_e              st_q, st_d;
    logic [VA_W-1:0]       page_q, req_page;
    logic [PAGE_SHIFT-1:0] off_q;
    logic                  wr_q;
    logic [PA_W-1:0]       ent_q, ent_d;
    logic [PTE_W-1:0]      pte_q;
    xlate_rsp_t            rsp_q, chk_rsp;
    logic                  fault_set;

    assign req_page = {req_addr_i[VA_W-1:PAGE_SHIFT], {PAGE_SHIFT{1'b0}}};

    dxw_entry_addr u_addr (
        .base_i  (cfg_base_i),
        .page_i  (req_page),
        .range_i (cfg_range_i),
        .addr_o  (ent_d)
    );

    dxw_pte_check u_chk (
        .pte_i   (pte_q),
        .page_i  (page_q),
        .off_i   (off_q),
        .write_i (wr_q),
        .rsp_o   (chk_rsp)
    );

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:  if (req_valid_i)  st_d = ST_ISSUE;
            ST_ISSUE: if (mem_gnt_i)    st_d = ST_WAIT;
            ST_WAIT:  if (mem_rvalid_i) st_d = ST_CHECK;
            ST_CHECK:                   st_d = ST_RESP;
            ST_RESP:  if (rsp_ready_i)  st_d = ST_IDLE;
            default:                    st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            page_q <= '0;
            off_q  <= '0;
            wr_q   <= 1'b0;
            ent_q  <= '0;
            pte_q  <= '0;
            rsp_q  <= '0;
        end else begin
            st_q <= st_d;
            if (st_q == ST_IDLE && req_valid_i) begin
                page_q <= req_page;
                off_q  <= req_addr_i[PAGE_SHIFT-1:0];
                wr_q   <= req_write_i;
                ent_q  <= ent_d;
            end
            if (st_q == ST_WAIT && mem_rvalid_i)
                pte_q <= be_assemble(mem_rdata_i);
            if (st_q == ST_CHECK)
                rsp_q <= chk_rsp;
        end
    end

    assign fault_set = (st_q == ST_CHECK) && chk_rsp.fault;

    dxw_fault_regs u_fault (
        .clk        (clk),
        .rst        (rst),
        .set_i      (fault_set),
        .set_read_i (!wr_q),
        .set_addr_i (page_q),
        .ack_i      (fault_ack_i),
        .status_o   (fault_status_o),
        .addr_o     (fault_addr_o),
        .irq_o      (irq_o)
    );

    assign req_ready_o = (st_q == ST_IDLE);
    assign mem_req_o   = (st_q == ST_ISSUE);
    assign mem_addr_o  = ent_q;
    assign rsp_valid_o = (st_q == ST_RESP);
    assign rsp_fault_o = rsp_q.fault;
    assign rsp_perm_o  = rsp_q.perm;
    assign rsp_pa_o    = rsp_q.pa;
    assign rsp_iova_o  = rsp_q.iova;
    assign rsp_mask_o  = rsp_q.mask;

    assert_single_accept_R1: assert property (@(posedge clk) disable iff (rst)
        (req_valid_i && req_ready_o) |=> !req_ready_o);
    assert_mem_hold_R13: assert property (@(posedge clk) disable iff (rst)
        (mem_req_o && !mem_gnt_i) |=> (mem_req_o && $stable(mem_addr_o)));
    assert_rsp_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid_o && !rsp_ready_i) |=> (rsp_valid_o && $stable(rsp_pa_o)
            && $stable(rsp_fault_o) && $stable(rsp_perm_o) && $stable(rsp_iova_o)));
    assert_fault_fields_R9: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid_o && rsp_fault_o) |-> (rsp_perm_o == 2'b00 && rsp_pa_o == '0
            && rsp_mask_o == '1));
    assert_fault_irq_R8: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid_o && rsp_fault_o && !$past(rsp_valid_o)) |-> irq_o);
endmodule

// File: tb/dma_xlate_walker_tb.sv
module dma_xlate_walker_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] cfg_base = 32'h0000_1000;
    logic [2:0]  cfg_range = 3'd0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic        mem_req, mem_gnt = 1'b0, mem_rvalid = 1'b0;
    logic [35:0] mem_addr;
    logic [31:0] mem_rdata = '0;
    logic        rsp_valid, rsp_ready = 1'b0, rsp_fault;
    logic [1:0]  rsp_perm;
    logic [35:0] rsp_pa;
    logic [31:0] rsp_iova, rsp_mask;
    logic        fault_ack = 1'b0;
    logic [31:0] fault_status, fault_addr;
    logic        irq;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_xlate_walker u_dut (
        .clk(clk), .rst(rst), .cfg_base_i(cfg_base), .cfg_range_i(cfg_range),
        .req_valid_i(req_valid), .req_ready_o(req_ready), .req_addr_i(req_addr),
        .req_write_i(req_write), .mem_req_o(mem_req), .mem_gnt_i(mem_gnt),
        .mem_addr_o(mem_addr), .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata),
        .rsp_valid_o(rsp_valid), .rsp_ready_i(rsp_ready), .rsp_fault_o(rsp_fault),
        .rsp_perm_o(rsp_perm), .rsp_pa_o(rsp_pa), .rsp_iova_o(rsp_iova),
        .rsp_mask_o(rsp_mask), .fault_ack_i(fault_ack), .fault_status_o(fault_status),
        .fault_addr_o(fault_addr), .irq_o(irq)
    );

    typedef struct {
        logic        fault;
        logic [1:0]  perm;
        logic [35:0] pa;
        logic [31:0] iova, mask, fst, fad;
    } exp_t;

    exp_t        exp_q[$];
    logic [35:0] ent_q[$];
    logic [31:0] table_mem [logic [35:0]];
    int n_chk = 0, n_bad = 0;
    bit done = 0;

    task automatic cmp(string tag, logic [63:0] act, logic [63:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    function automatic logic [35:0] ent_addr(logic [31:0] va, logic [2:0] code);
        logic [31:0] m, ix;
        m  = (32'h1 << (24 + code)) - 32'h1;
        ix = (((va & 32'hFFFF_F000) & m) >> 10) & 32'hFFFF_FFFC;
        return {cfg_base, 4'h0} + {4'h0, ix};
    endfunction

    task automatic put(logic [31:0] va, logic [31:0] pte);
        table_mem[ent_addr(va, cfg_range)] = pte;
    endtask

    task automatic do_req(logic [31:0] va, logic wr);
        exp_t e;
        logic [35:0] a;
        logic [31:0] pte;
        a   = ent_addr(va, cfg_range);
        pte = table_mem.exists(a) ? table_mem[a] : 32'h0;
        e.fault = !pte[1] || (wr && !pte[2]);
        if (e.fault) begin
            e.perm = 2'b00; e.pa = '0; e.iova = '0; e.mask = 32'hFFFF_FFFF;
            e.fst  = wr ? 32'hC082_0000 : 32'hC086_0000;
            e.fad  = va & 32'hFFFF_F000;
        end else begin
            e.perm = pte[2] ? 2'b11 : 2'b01;
            e.pa   = {pte[31:8], va[11:0]};
            e.iova = va & 32'hFFFF_F000;
            e.mask = 32'h0000_0FFF;
            e.fst  = '0; e.fad = '0;
        end
        exp_q.push_back(e);
        ent_q.push_back(a);
        req_addr  = va;
        req_write = wr;
        req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        cmp("R1 busy after accept", {63'h0, req_ready}, 64'h0);
        req_valid = 1'b0;
    endtask

    // memory model: grant and data after varying delays, big-endian lanes
    initial begin : mem_model
        int k = 0;
        logic [35:0] a, ea;
        logic [31:0] pte;
        forever begin
            @(negedge clk);
            if (mem_req) begin
                a  = mem_addr;
                ea = (ent_q.size() > 0) ? ent_q.pop_front() : 36'hF_FFFF_FFFF;
                cmp("R2 entry address", {28'h0, a}, {28'h0, ea});
                repeat (k % 3) @(negedge clk);
                mem_gnt = 1'b1;
                @(negedge clk);
                mem_gnt = 1'b0;
                repeat (k % 4) @(negedge clk);
                pte = table_mem.exists(a) ? table_mem[a] : 32'h0;
                mem_rdata  = {pte[7:0], pte[15:8], pte[23:16], pte[31:24]};
                mem_rvalid = 1'b1;
                @(negedge clk);
                mem_rvalid = 1'b0;
                mem_rdata  = 32'hDEAD_BEEF;
                k++;
            end
        end
    end

    // monitor: scoreboard against expected queue, with back-pressure
    initial begin : monitor
        int stall = 1;
        int s = 0;
        exp_t e;
        forever begin
            @(negedge clk);
            if (rsp_valid) begin
                if (stall > 0) begin
                    rsp_ready = 1'b0;
                    stall--;
                end else begin
                    rsp_ready = 1'b1;
                    if (exp_q.size() == 0) begin
                        cmp("R1 unexpected response", 64'h1, 64'h0);
                    end else begin
                        e = exp_q.pop_front();
                        cmp("R6/R7 fault flag", {63'h0, rsp_fault}, {63'h0, e.fault});
                        cmp("R5/R9 perm", {62'h0, rsp_perm}, {62'h0, e.perm});
                        cmp("R4/R9 pa", {28'h0, rsp_pa}, {28'h0, e.pa});
                        cmp("R5/R9 iova", {32'h0, rsp_iova}, {32'h0, e.iova});
                        cmp("R5/R9 mask", {32'h0, rsp_mask}, {32'h0, e.mask});
                        if (e.fault) begin
                            cmp("R8 fault status", {32'h0, fault_status}, {32'h0, e.fst});
                            cmp("R8 fault addr", {32'h0, fault_addr}, {32'h0, e.fad});
                            cmp("R8 irq", {63'h0, irq}, 64'h1);
                        end
                    end
                    s++;
                    stall = s % 3;
                end
            end else begin
                rsp_ready = 1'b0;
            end
        end
    end

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic ack_and_check();
        logic [31:0] st, fa;
        st = fault_status;
        fa = fault_addr;
        fault_ack = 1'b1;
        @(negedge clk);
        fault_ack = 1'b0;
        cmp("R11 irq cleared", {63'h0, irq}, 64'h0);
        cmp("R11 status kept", {32'h0, fault_status}, {32'h0, st});
        cmp("R11 addr kept", {32'h0, fault_addr}, {32'h0, fa});
    endtask

    initial begin : stimulus
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        cmp("R12 ready", {63'h0, req_ready}, 64'h1);
        cmp("R12 rsp_valid", {63'h0, rsp_valid}, 64'h0);
        cmp("R12 mem_req", {63'h0, mem_req}, 64'h0);
        cmp("R12 irq", {63'h0, irq}, 64'h0);
        cmp("R12 status", {32'h0, fault_status}, 64'h0080_0000);
        cmp("R12 fault addr", {32'h0, fault_addr}, 64'h0);

        // 16 MB window
        put(32'h0012_3000, 32'hABCD_E182);   // valid, read-only, cache bit set
        put(32'h0020_0000, 32'h1234_5686);   // valid, writable
        put(32'h0040_0000, 32'hFFFF_FF06);   // top page number
        put(32'h0050_0000, 32'h0000_0104);   // writable but not valid
        do_req(32'h0012_3456, 1'b0);         // R3 R4 R5 read-only
        do_req(32'h0020_0ABC, 1'b1);         // R5 read-write
        do_req(32'h0020_0001, 1'b0);         // R7 read of writable
        do_req(32'hFF12_3789, 1'b0);         // R2 bits above window ignored
        do_req(32'h0040_0FFF, 1'b0);         // R4 highest address
        drain();

        do_req(32'h0012_3010, 1'b1);         // R7 write to read-only
        drain();
        ack_and_check();

        do_req(32'h0030_0000, 1'b0);         // R6 absent entry, read
        drain();
        ack_and_check();

        do_req(32'h0050_0123, 1'b1);         // R6 invalid though writable
        do_req(32'h0012_3FFF, 1'b0);         // success after fault
        drain();
        cmp("R8 irq stays until ack", {63'h0, irq}, 64'h1);
        ack_and_check();

        // 2 GB window
        cfg_range = 3'd7;
        put(32'h4000_0000, 32'h0765_4302);
        do_req(32'hC000_0123, 1'b0);         // R2 bit 31 ignored
        do_req(32'h4000_0456, 1'b0);
        do_req(32'h4000_0456, 1'b1);         // R7 write fault
        drain();

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog R1 actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule